// File: doc/BRIEF.md
# Cascaded Lockable Watchdog Timer

This block is a watchdog made of two 8-bit down-counters. A low stage is driven by a divide-by-16 prescaler of the main clock. A high stage takes its decrements either from the low stage's underflow (cascaded) or directly from the prescaler. When the high stage underflows, the block emits a one-cycle internal reset. That pulse also returns the watchdog itself to its power-on state.

Software controls the block through a single 8-bit control register on a simple write-strobe bus. The timer is disarmed out of reset and starts only after the first write. Every later write refreshes both stages to 0xFF.

A write-once configuration bit chooses how a stop-instruction strobe is handled. With the bit clear, the strobe places the block in stop mode. With the bit set, the strobe forces an internal reset. While stop mode is active the counters are frozen. A wake input ends stop mode. Reading the register returns the live upper bits of the high stage together with the two stored control bits.

Top module: `lockable_wdt`

## Requirements
- R1: After asynchronous reset, `reg_rdata_o` reads 0x3F, `sys_rst_o` is 0 and `stop_req_o` is 0.
- R2: Until the first register write after reset, the counters do not run and no watchdog reset is produced. The read value stays 0x3F.
- R3: Every write reloads both stages to 0xFF, whatever bits 5..0 hold. The prescaler restarts, so the first decrement lands on the 16th enabled clock after the write edge.
- R4: With bit 7 = 1 (direct mode), the high stage decrements once per 16 enabled clocks. `sys_rst_o` is high during the cycle that follows the 4096th enabled clock edge after the last write.
- R5: With bit 7 = 0 (cascaded mode), the high stage decrements once per 256 low-stage decrements. Read bits 5..0 change from 0x3F to 0x3E exactly 16384 enabled clocks after the write.
- R6: Bit 7 takes the written value on every write.
- R7: Bit 6 takes the written value only on the first write after reset. Later writes leave it unchanged.
- R8: A `stop_exec_i` strobe with bit 6 = 0 raises `stop_req_o`, which stays high until a `stop_wake_i` strobe. No reset results from this strobe.
- R9: A `stop_exec_i` strobe with bit 6 = 1 makes `sys_rst_o` high in the following cycle.
- R10: The counters and prescaler hold while `stop_req_o` is high or `clk_en_i` is low, and they resume afterwards.
- R11: `sys_rst_o` lasts exactly one cycle. It restores the reset state: disarmed, bits 7 and 6 cleared and unlocked, stop mode cleared.
- R12: A write in the same cycle as the tick that would underflow the high stage reloads the counters, and no reset is issued.
- R13: The read value is {bit 7, bit 6, high stage bits 7..2}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_en_i | input | 1 | Main clock enable; each enabled cycle counts one main-clock period |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Write data (bit 7 high-stage source, bit 6 stop behaviour) |
| reg_rdata_o | output | 8 | Read data: {bit 7, bit 6, high stage [7:2]} |
| stop_exec_i | input | 1 | Stop-instruction strobe |
| stop_wake_i | input | 1 | Stop mode release strobe |
| stop_req_o | output | 1 | Stop mode active |
| sys_rst_o | output | 1 | One-cycle internal reset pulse |

## Verification
The conflicting pair is a software refresh and the prescaler tick that would underflow the high stage. In direct mode the bench writes once, counts exactly 4096 enabled edges, and places the second write on that tick's edge. It then requires `sys_rst_o` to stay low and the read field to show a fresh 0x3F. A write landing one cycle later must instead see the pulse on the cycle after the 4096th edge, followed by a read of 0x3F showing the restored reset state.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned CTL_W       = 8;
  localparam int unsigned SRC_BIT     = 7;
  localparam int unsigned STP_BIT     = 6;
  localparam int unsigned RD_FIELD_W  = 6;
  localparam int unsigned N_STAGES    = 2;

  typedef struct packed {
    logic h_direct;   // high stage fed by prescaler instead of low underflow
    logic stop_rst;   // stop strobe forces reset
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (&cnt_q);
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         uflow_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (load_i) cnt_q <= '1;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o   = cnt_q;
  assign uflow_o = dec_i && (cnt_q == '0);
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             stop_exec_i,
  input  logic             wake_i,
  input  logic             h_uflow_i,
  output logic             armed_o,
  output wdt_cfg_t         cfg_o,
  output logic             stop_mode_o,
  output logic             reload_o,
  output logic             rst_pulse_o
);
  logic     armed_q, stop_q, pulse_q;
  wdt_cfg_t cfg_q;
  logic     soft_clr;

  // a refresh in the underflow cycle wins; a stop-reset always wins
  assign soft_clr = (h_uflow_i && !we_i) || (stop_exec_i && cfg_q.stop_rst);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      cfg_q   <= '0;
      stop_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= soft_clr;
      if (soft_clr) begin
        armed_q <= 1'b0;
        cfg_q   <= '0;
        stop_q  <= 1'b0;
      end else begin
        if (we_i) begin
          armed_q        <= 1'b1;
          cfg_q.h_direct <= wdata_i[SRC_BIT];
          if (!armed_q) cfg_q.stop_rst <= wdata_i[STP_BIT];
        end
        if (stop_q && wake_i)                               stop_q <= 1'b0;
        else if (!stop_q && stop_exec_i && !cfg_q.stop_rst) stop_q <= 1'b1;
      end
    end
  end

  assign armed_o     = armed_q;
  assign cfg_o       = cfg_q;
  assign stop_mode_o = stop_q;
  assign reload_o    = we_i || soft_clr;
  assign rst_pulse_o = pulse_q;
endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned DIV_W = 4,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             reg_we_i,
  input  logic [CTL_W-1:0] reg_wdata_i,
  output logic [CTL_W-1:0] reg_rdata_o,
  input  logic             stop_exec_i,
  input  logic             stop_wake_i,
  output logic             stop_req_o,
  output logic             sys_rst_o
);
  localparam int unsigned RD_MSB = CNT_W - 1;

  logic                         armed, stop_mode, reload, run, tick, h_uflow;
  wdt_cfg_t                     cfg;
  logic [N_STAGES-1:0]          dec, uflow;
  logic [N_STAGES-1:0][CNT_W-1:0] cnt;

  wdt_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .wdata_i     (reg_wdata_i),
    .stop_exec_i (stop_exec_i),
    .wake_i      (stop_wake_i),
    .h_uflow_i   (h_uflow),
    .armed_o     (armed),
    .cfg_o       (cfg),
    .stop_mode_o (stop_mode),
    .reload_o    (reload),
    .rst_pulse_o (sys_rst_o)
  );

  assign run = armed && !stop_mode && clk_en_i;

  wdt_prescaler #(.DIV_W(DIV_W)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (reload),
    .run_i  (run),
    .tick_o (tick)
  );

  assign dec[0] = tick;
  assign dec[1] = cfg.h_direct ? tick : uflow[0];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    wdt_stage #(.W(CNT_W)) u_stage (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (reload),
      .dec_i   (dec[g]),
      .cnt_o   (cnt[g]),
      .uflow_o (uflow[g])
    );
  end

  assign h_uflow     = uflow[N_STAGES-1];
  assign stop_req_o  = stop_mode;
  assign reg_rdata_o = {cfg.h_direct, cfg.stop_rst, cnt[N_STAGES-1][RD_MSB -: RD_FIELD_W]};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       clk_en_i,
  input logic       reg_we_i,
  input logic [7:0] reg_rdata_o,
  input logic       stop_exec_i,
  input logic       stop_req_o,
  input logic       sys_rst_o,
  input logic       h_uflow,
  input logic       armed
);
  p_no_reset_disarmed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !stop_exec_i) |=> !sys_rst_o);

  p_write_reloads_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !(stop_exec_i && reg_rdata_o[6])) |=> (reg_rdata_o[5:0] == 6'h3F) && !sys_rst_o);

  p_bit6_locked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[6] |=> (reg_rdata_o[6] || sys_rst_o));

  p_stop_enter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_exec_i && !reg_rdata_o[6] && !stop_req_o && !h_uflow) |=> stop_req_o && !sys_rst_o);

  p_stop_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_exec_i && reg_rdata_o[6]) |=> sys_rst_o);

  p_hold_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_req_o && !reg_we_i && !stop_exec_i) |=> $stable(reg_rdata_o[5:0]));

  p_hold_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && !reg_we_i && !stop_exec_i) |=> $stable(reg_rdata_o[5:0]));

  p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);

  p_pulse_restores_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> (reg_rdata_o == 8'h3F) && !stop_req_o && !armed);

  p_refresh_wins_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_uflow && reg_we_i && !stop_exec_i) |=> !sys_rst_o);
endmodule

bind lockable_wdt wdt_checker u_wdt_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clk_en_i    (clk_en_i),
  .reg_we_i    (reg_we_i),
  .reg_rdata_o (reg_rdata_o),
  .stop_exec_i (stop_exec_i),
  .stop_req_o  (stop_req_o),
  .sys_rst_o   (sys_rst_o),
  .h_uflow     (h_uflow),
  .armed       (armed)
);

// File: tb/lockable_wdt_test.sv
`timescale 1ns/1ps
module lockable_wdt_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clk_en = 1'b1;
  logic       we = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       stop_exec = 1'b0;
  logic       wake = 1'b0;
  logic       stop_req, sys_rst;
  int         n_chk = 0;
  int         n_fail = 0;

  always #4 clk = ~clk;

  lockable_wdt uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .clk_en_i    (clk_en),
    .reg_we_i    (we),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .stop_exec_i (stop_exec),
    .stop_wake_i (wake),
    .stop_req_o  (stop_req),
    .sys_rst_o   (sys_rst)
  );

  // {do_write, wdata, idle negedges, expected read}
  localparam logic [32:0] VEC [7] = '{
    {1'b0, 8'h00, 16'd100,   8'h3F},  // R2 disarmed
    {1'b1, 8'h3F, 16'd0,     8'h3F},  // R3 low bits ignored, R13
    {1'b0, 8'h00, 16'd16383, 8'h3F},  // R5 before step
    {1'b0, 8'h00, 16'd1,     8'h3E},  // R5 step
    {1'b1, 8'hC0, 16'd0,     8'hBF},  // R6 bit7 set, R7 bit6 locked
    {1'b0, 8'h00, 16'd2047,  8'hA0},  // R4 direct rate, R13 H=0x80
    {1'b1, 8'h15, 16'd0,     8'h3F}   // R6 bit7 cleared, R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hw_reset();
    rst_ni = 1'b0;
    idle(2);
    rst_ni = 1'b1;
    idle(1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(2);
    rst_ni = 1'b1;
    idle(1);
    chk("R1 read", rdata, 8'h3F);
    chk("R1 rst", {7'd0, sys_rst}, 8'h00);
    chk("R1 stop", {7'd0, stop_req}, 8'h00);

    for (int v = 0; v < 7; v++) begin
      if (VEC[v][32]) wr(VEC[v][31:24]);
      idle(int'(VEC[v][23:8]));
      chk($sformatf("vector %0d R2/R3/R5/R6/R7/R13 read", v), rdata, VEC[v][7:0]);
      chk($sformatf("vector %0d R2 no rst", v), {7'd0, sys_rst}, 8'h00);
    end

    // R4 / R11: direct underflow, one-cycle pulse, full restore
    hw_reset();
    wr(8'h80);
    idle(4095);
    chk("R4 before underflow", {7'd0, sys_rst}, 8'h00);
    idle(1);
    chk("R4 pulse", {7'd0, sys_rst}, 8'h01);
    chk("R11 read at pulse", rdata, 8'h3F);
    idle(1);
    chk("R11 single cycle", {7'd0, sys_rst}, 8'h00);
    idle(5000);
    chk("R11 disarmed no rst", {7'd0, sys_rst}, 8'h00);
    chk("R11 disarmed read", rdata, 8'h3F);
    wr(8'h40);
    chk("R11 bit6 unlocked", rdata, 8'h7F);

    // R12: refresh on the underflow tick
    hw_reset();
    wr(8'h80);
    idle(4095);
    wr(8'h80);
    chk("R12 no rst", {7'd0, sys_rst}, 8'h00);
    chk("R12 reloaded", rdata, 8'hBF);

    // R7: write-once bit 6, R6 bit 7 follows each write
    hw_reset();
    wr(8'h40);
    chk("R7 first write", rdata, 8'h7F);
    wr(8'h00);
    chk("R7 later write ignored", rdata, 8'h7F);
    wr(8'h80);
    chk("R6 bit7 update", rdata, 8'hFF);

    // R9: stop strobe with bit6 set
    stop_exec = 1'b1;
    idle(1);
    stop_exec = 1'b0;
    chk("R9 pulse", {7'd0, sys_rst}, 8'h01);
    chk("R9 no stop", {7'd0, stop_req}, 8'h00);
    idle(1);
    chk("R9 pulse ends R11", {7'd0, sys_rst}, 8'h00);

    // R8 / R10: stop mode freezes counters
    hw_reset();
    wr(8'h80);
    idle(160);
    chk("R10 before stop", rdata, 8'hBD);
    stop_exec = 1'b1;
    idle(1);
    stop_exec = 1'b0;
    chk("R8 stop req", {7'd0, stop_req}, 8'h01);
    idle(1000);
    chk("R10 held in stop", rdata, 8'hBD);
    chk("R8 still stopped", {7'd0, stop_req}, 8'h01);
    chk("R8 no rst", {7'd0, sys_rst}, 8'h00);
    wake = 1'b1;
    idle(1);
    wake = 1'b0;
    chk("R8 wake", {7'd0, stop_req}, 8'h00);
    idle(192);
    chk("R10 resumed", rdata, 8'hBA);

    // R10: clock enable gating shifts the underflow
    hw_reset();
    wr(8'h80);
    clk_en = 1'b0;
    idle(500);
    chk("R10 gated hold", rdata, 8'hBF);
    clk_en = 1'b1;
    idle(4095);
    chk("R10 gated no early rst", {7'd0, sys_rst}, 8'h00);
    idle(1);
    chk("R10 R4 gated pulse", {7'd0, sys_rst}, 8'h01);

    finish_run();
  end
endmodule